// File: doc/BRIEF.md
# Tile Recognition Match Selector

The block picks which stored tile type goes into the next site of a grid that is being assembled. The grid walk happens elsewhere. For each query it receives three things: the plug pattern exposed by the tile already sitting to the left, the plug pattern exposed by the tile above, and the socket patterns of every stored candidate type.

It evaluates all candidates in parallel:

- A candidate is rejected if any of its sockets disagrees with the plug facing it.
- Each surviving candidate is scored by how many plug/socket pairs carry the same real symbol. An empty position on either side fits anything but adds nothing to the score.
- The highest score wins. On a tie, the candidate with the higher storage index wins.
- If no candidate survives, an all-empty fallback tile is reported instead.

A query is made by pulsing `req_valid`. The answer appears one cycle later with `rsp_valid` and stays held until the next query.

Top module: `tile_match_select`

## Requirements
- R1: While `rst_n` is low, `rsp_valid`, `rsp_place`, `rsp_default`, `rsp_index` and `rsp_energy` are all 0.
- R2: A query sampled with `req_valid` high at a rising edge produces `rsp_valid` high after that edge, and `rsp_valid` is low after an edge with no query. The other response outputs change only after an edge that accepted a query.
- R3: Each edge holds POS positions. Position k of an edge pattern occupies bits [2k+1:2k]. Position k of candidate i occupies bits [(i*POS+k)*2+1 : (i*POS+k)*2] of the socket bus for that edge. Code 00 means empty; codes 01, 10 and 11 are symbols. A candidate is rejected if, at any position of either edge, plug and socket are both nonzero and unequal.
- R4: The energy of a surviving candidate is the number of positions on both edges where plug and socket are equal and nonzero. Its range is 0 to 2*POS.
- R5: Among surviving candidates, the one with the highest energy is reported in `rsp_index`, and its energy is reported in `rsp_energy`.
- R6: When several surviving candidates share the highest energy, the one with the largest index is reported.
- R7: When no candidate survives, `rsp_default` is 1, `rsp_index` is 0 and `rsp_energy` is 0. Otherwise `rsp_default` is 0.
- R8: A query with `left_present` or `up_present` low places nothing. The response then has `rsp_place`, `rsp_default`, `rsp_index` and `rsp_energy` all at 0. When both neighbours are present, `rsp_place` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Query strobe |
| left_present | input | 1 | Left neighbour already placed |
| up_present | input | 1 | Upper neighbour already placed |
| left_plug | input | POS*2 | Plugs of the left neighbour facing this site |
| up_plug | input | POS*2 | Plugs of the upper neighbour facing this site |
| cand_left_sock | input | NUM*POS*2 | Left-edge sockets of all candidates |
| cand_up_sock | input | NUM*POS*2 | Upper-edge sockets of all candidates |
| rsp_valid | output | 1 | Response strobe, one cycle after the query |
| rsp_place | output | 1 | Both neighbours were present |
| rsp_default | output | 1 | Fallback tile selected |
| rsp_index | output | clog2(NUM) | Winning candidate index |
| rsp_energy | output | clog2(2*POS+1) | Binding energy of the winner |

## Verification
The bench targets a set of corner cases:

- **All-empty sockets.** Every candidate survives with zero energy, so the last index must win. A design that keeps the first candidate on ties, or that treats empty as a mismatch, reports index 0 or the fallback.
- **Empty plugs.** The same outcome is expected. This catches a design that counts two empty positions as a true match, because it would report a nonzero energy.
- **Universal mismatch.** This must raise the fallback flag. A design with an inverted mismatch test would report a real candidate instead.
- **Directed ties and near-ties, plus absent neighbours.** Directed cases cover ties and near-ties in energy, and queries with either neighbour missing. Biased random queries then mix partial matches with wildcards, to expose errors in counting or rejection.

// File: rtl/tile_match_select.sv
module tile_match_select #(
  parameter int NUM = 8,
  parameter int POS = 2,
  parameter int SYM_W = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic                         left_present,
  input  logic                         up_present,
  input  logic [POS*SYM_W-1:0]         left_plug,
  input  logic [POS*SYM_W-1:0]         up_plug,
  input  logic [NUM*POS*SYM_W-1:0]     cand_left_sock,
  input  logic [NUM*POS*SYM_W-1:0]     cand_up_sock,
  output logic                         rsp_valid,
  output logic                         rsp_place,
  output logic                         rsp_default,
  output logic [$clog2(NUM)-1:0]       rsp_index,
  output logic [$clog2(2*POS+1)-1:0]   rsp_energy
);
  localparam int EDGE_W = POS*SYM_W;
  localparam int IDX_W  = $clog2(NUM);
  localparam int EN_W   = $clog2(2*POS+1);

  // {survives, energy}
  function automatic logic [EN_W:0] rate(input logic [EDGE_W-1:0] pl, pu, sl, su);
    logic ok;
    logic [EN_W-1:0] e;
    ok = 1'b1;
    e  = '0;
    for (int k = 0; k < POS; k++) begin
      if (pl[k*SYM_W +: SYM_W] != '0 && sl[k*SYM_W +: SYM_W] != '0) begin
        if (pl[k*SYM_W +: SYM_W] == sl[k*SYM_W +: SYM_W]) e = e + 1'b1;
        else ok = 1'b0;
      end
      if (pu[k*SYM_W +: SYM_W] != '0 && su[k*SYM_W +: SYM_W] != '0) begin
        if (pu[k*SYM_W +: SYM_W] == su[k*SYM_W +: SYM_W]) e = e + 1'b1;
        else ok = 1'b0;
      end
    end
    return {ok, e};
  endfunction

  logic [NUM-1:0]  cand_ok;
  logic [EN_W-1:0] cand_e [NUM];

  for (genvar i = 0; i < NUM; i++) begin : g_cand
    logic [EN_W:0] r;
    assign r = rate(left_plug, up_plug,
                    cand_left_sock[i*EDGE_W +: EDGE_W],
                    cand_up_sock[i*EDGE_W +: EDGE_W]);
    assign cand_ok[i] = r[EN_W];
    assign cand_e[i]  = r[EN_W-1:0];
  end

  logic             any_ok;
  logic [IDX_W-1:0] best_i;
  logic [EN_W-1:0]  best_e;
  logic             both_here;

  always_comb begin
    any_ok = 1'b0;
    best_i = '0;
    best_e = '0;
    for (int i = 0; i < NUM; i++) begin
      if (cand_ok[i] && (!any_ok || cand_e[i] >= best_e)) begin
        any_ok = 1'b1;
        best_i = IDX_W'(i);
        best_e = cand_e[i];
      end
    end
  end

  assign both_here = left_present & up_present;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_place   <= 1'b0;
      rsp_default <= 1'b0;
      rsp_index   <= '0;
      rsp_energy  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_place   <= both_here;
        rsp_default <= both_here & ~any_ok;
        rsp_index   <= (both_here & any_ok) ? best_i : '0;
        rsp_energy  <= (both_here & any_ok) ? best_e : '0;
      end
    end
  end
endmodule

// File: rtl/tile_match_select_chk.sv
module tile_match_select_chk #(
  parameter int NUM = 8,
  parameter int POS = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       rsp_valid,
  input logic                       rsp_place,
  input logic                       rsp_default,
  input logic [$clog2(NUM)-1:0]     rsp_index,
  input logic [$clog2(2*POS+1)-1:0] rsp_energy
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(rsp_index) && $stable(rsp_energy) && $stable(rsp_default) && $stable(rsp_place)));
  a_r4_energy_cap: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_energy <= ($clog2(2*POS+1))'(2*POS));
  a_r7_default_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_default |-> (rsp_index == '0 && rsp_energy == '0 && rsp_place));
  a_r8_no_place: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_place |-> (!rsp_default && rsp_index == '0 && rsp_energy == '0));
endmodule

bind tile_match_select tile_match_select_chk #(.NUM(NUM), .POS(POS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_place(rsp_place), .rsp_default(rsp_default),
  .rsp_index(rsp_index), .rsp_energy(rsp_energy));

// File: tb/tile_match_select_bench.sv
module tile_match_select_bench;
  localparam int NUM = 8;
  localparam int POS = 2;
  localparam int EW  = POS*2;
  localparam int IW  = $clog2(NUM);
  localparam int ENW = $clog2(2*POS+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, left_present = 1'b0, up_present = 1'b0;
  logic [EW-1:0] left_plug = '0, up_plug = '0;
  logic [NUM*EW-1:0] sl = '0, su = '0;
  logic rsp_valid, rsp_place, rsp_default;
  logic [IW-1:0] rsp_index;
  logic [ENW-1:0] rsp_energy;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  tile_match_select #(.NUM(NUM), .POS(POS), .SYM_W(2)) u_tile_match_select (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .left_present(left_present), .up_present(up_present),
    .left_plug(left_plug), .up_plug(up_plug),
    .cand_left_sock(sl), .cand_up_sock(su),
    .rsp_valid(rsp_valid), .rsp_place(rsp_place), .rsp_default(rsp_default),
    .rsp_index(rsp_index), .rsp_energy(rsp_energy));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // pair score: -1 means conflict
  function automatic int pair(input logic [1:0] p, input logic [1:0] s);
    if (p == 2'b00 || s == 2'b00) return 0;
    return (p == s) ? 1 : -1;
  endfunction

  task automatic query(input logic lp_ok, input logic up_ok);
    int eidx, een;
    logic edef;
    eidx = 0; een = -1; edef = 1'b1;
    for (int i = NUM-1; i >= 0; i--) begin
      int e;
      logic bad;
      e = 0; bad = 1'b0;
      for (int k = 0; k < POS; k++) begin
        int a, b;
        a = pair(left_plug[2*k +: 2], sl[(i*POS+k)*2 +: 2]);
        b = pair(up_plug[2*k +: 2], su[(i*POS+k)*2 +: 2]);
        if (a < 0 || b < 0) bad = 1'b1;
        else e += a + b;
      end
      if (!bad && e > een) begin een = e; eidx = i; edef = 1'b0; end
    end
    if (edef) een = 0;
    if (!(lp_ok && up_ok)) begin eidx = 0; een = 0; edef = 1'b0; end
    @(negedge clk);
    left_present = lp_ok; up_present = up_ok; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 rsp_valid", rsp_valid, 1);
    chk("R8 rsp_place", rsp_place, int'(lp_ok && up_ok));
    chk("R7 rsp_default", rsp_default, int'(edef));
    chk("R5 R6 rsp_index", rsp_index, eidx);
    chk("R4 rsp_energy", rsp_energy, een);
  endtask

  function automatic logic [1:0] rsym(input int empty_pct);
    if (($urandom % 100) < empty_pct) return 2'b00;
    return 2'($urandom_range(1, 3));
  endfunction

  initial begin
    int seed;
    logic [IW-1:0] held_i;
    seed = $urandom(1234);
    #1;
    chk("R1 rsp_valid reset", rsp_valid, 0);
    chk("R1 rsp_index reset", rsp_index, 0);
    chk("R1 rsp_default reset", rsp_default, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R6: all sockets empty -> all tie at 0, last index
    left_plug = 4'b1101; up_plug = 4'b0110; sl = '0; su = '0;
    query(1, 1);
    // R3: empty plugs fit anything, no energy
    left_plug = '0; up_plug = '0;
    for (int i = 0; i < NUM*EW; i++) begin sl[i] = 1'b1; su[i] = 1'b0; end
    query(1, 1);
    // R7: every candidate conflicts
    left_plug = 4'b0101; up_plug = 4'b0101;
    for (int i = 0; i < NUM*POS; i++) begin sl[2*i +: 2] = 2'b10; su[2*i +: 2] = 2'b10; end
    query(1, 1);
    // R5: candidate 2 full match beats candidate 5 partial
    left_plug = 4'b1101; up_plug = 4'b0111;
    sl[2*EW +: EW] = 4'b1101; su[2*EW +: EW] = 4'b0111;
    sl[5*EW +: EW] = 4'b0001; su[5*EW +: EW] = 4'b0011;
    query(1, 1);
    // R6: tie between 2 and 6 at full energy
    sl[6*EW +: EW] = 4'b1101; su[6*EW +: EW] = 4'b0111;
    query(1, 1);
    // R8: neighbour missing
    query(0, 1);
    query(1, 0);
    // R2: idle cycle keeps response and drops valid
    query(1, 1);
    held_i = rsp_index;
    @(negedge clk);
    chk("R2 valid low when idle", rsp_valid, 0);
    chk("R2 index held", rsp_index, held_i);

    for (int n = 0; n < 400; n++) begin
      for (int k = 0; k < POS; k++) begin
        left_plug[2*k +: 2] = rsym(20);
        up_plug[2*k +: 2]   = rsym(20);
      end
      for (int i = 0; i < NUM*POS; i++) begin
        sl[2*i +: 2] = ($urandom % 2) ? left_plug[2*(i%POS) +: 2] : rsym(60);
        su[2*i +: 2] = ($urandom % 2) ? up_plug[2*(i%POS) +: 2] : rsym(60);
      end
      query(($urandom % 10) != 0, ($urandom % 10) != 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule